// File: doc/BRIEF.md
# Pre-trigger Logic Capture Controller

This block runs one acquisition of a multi-channel logic analyser. A host loads a sample total, a pre-trigger sample count and a 16-bit clock divisor through a small register port. While the acquisition is running, the block derives a sample strobe from the fast base clock by dividing it by the divisor. On each strobe it writes the input channels into a circular sample memory through a plain write port. The write address wraps at the memory depth, so the memory always holds the most recent samples.

A trigger input is accepted only after the configured number of pre-trigger samples has been stored. From that point the block keeps storing until the stored total reaches the sample total. It then reports the finished phase and stops driving the memory port. The host can then read back three values to plan the upload: the stored count, the count stored before the trigger, and the final write position. A mode bit sends the strobed samples to a streaming output instead of the memory. In that mode there is no trigger and no end point.

Top module: `pretrig_capture`

## Requirements
- R1: After reset the status word (address 0), the three readback registers (addresses 5, 6, 7), `memWrEn` and `streamValid` are all zero.
- R2: While recording, one sample is taken every D base-clock cycles, where D is the divisor at address 4 (value 0 acts as 1). The first sample is written D clock edges after the edge that accepts the start command.
- R3: Writing 3 to address 0 starts an acquisition from idle or finished. This clears the counts, the write position and the trigger flag. Any other non-zero value written to address 0 has no effect.
- R4: Status bits [1:0] read 0 when idle, 2 while recording and 1 when finished. Bits [3:2] read 3 once a trigger has been accepted and 0 otherwise. Higher bits read 0.
- R5: In memory mode (address 1 = 0), each sample drives `memWrEn` for one cycle with `memWrData` equal to `sampleIn`. Write addresses start at 0 and increase by one, wrapping modulo 2^AW.
- R6: A trigger is accepted only in a cycle where the stored count is at least the pre-trigger count (address 3). A trigger held high earlier is deferred until then.
- R7: After the trigger, capture finishes when the stored count reaches the sample total (address 2). After that no further memory writes occur.
- R8: Address 5 reads the stored count. Address 6 reads the stored count at the moment the trigger was accepted. Address 7 reads the next write position, which is the final position once capture has finished.
- R9: Writing 0 to address 0 returns the block to idle and stops writes. The readback registers keep their values.
- R10: Addresses 1 to 4 read back what was written, with the divisor 16 bits wide. Writes to them while recording are ignored.
- R11: In streaming mode (address 1 = 1), each sample drives `streamValid` with `streamData` equal to `sampleIn`. Memory is never written, the trigger is ignored, recording continues until stopped, and the stored count still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| sampleIn | input | CH | Channel inputs |
| trigIn | input | 1 | Trigger request from the matcher |
| memWrEn | output | 1 | Sample memory write enable |
| memAddr | output | AW | Sample memory write address |
| memWrData | output | CH | Sample memory write data |
| streamValid | output | 1 | Streaming-mode sample valid |
| streamData | output | CH | Streaming-mode sample data |

## Verification
The bench attacks the off-by-one spots: where the first sample falls after start, the spacing at divisors 0 and 3, and the wrap of the write address past the memory depth. An error in any of these shows up as a misplaced write or a wrong final position. It holds the trigger high before the pre-trigger window has filled; a design that accepts it early reports a pre-trigger count that is too small. It also checks that writes stop exactly at the total, and that stop, bad run codes and configuration writes during a run are ignored. A design that gets these wrong keeps writing into the memory or changes the window while it is being filled. Streaming mode is checked to never touch the memory and to ignore a trigger held high.

// File: rtl/pretrig_pkg.sv
package pretrig_pkg;
  localparam int REG_W  = 32;
  localparam int DIV_W  = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] REG_RUN   = 3'd0;
  localparam logic [ADDR_W-1:0] REG_MODE  = 3'd1;
  localparam logic [ADDR_W-1:0] REG_TOTAL = 3'd2;
  localparam logic [ADDR_W-1:0] REG_PRE   = 3'd3;
  localparam logic [ADDR_W-1:0] REG_DIV   = 3'd4;
  localparam logic [ADDR_W-1:0] REG_CNT   = 3'd5;
  localparam logic [ADDR_W-1:0] REG_PREST = 3'd6;
  localparam logic [ADDR_W-1:0] REG_POS   = 3'd7;

  localparam logic [REG_W-1:0] RUN_GO   = 32'd3;
  localparam logic [REG_W-1:0] RUN_HALT = 32'd0;

  localparam logic [1:0] PHASE_IDLE = 2'd0;
  localparam logic [1:0] PHASE_DONE = 2'd1;
  localparam logic [1:0] PHASE_REC  = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_POST, ST_DONE} capState_t;

  typedef struct packed {
    logic clear;
    logic run;
    logic advance;
    logic latchPre;
  } dpCmd_t;
endpackage

// File: rtl/pretrig_dp.sv
module pretrig_dp
  import pretrig_pkg::*;
#(
  parameter int CH = 16,
  parameter int AW = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [DIV_W-1:0] divisor,
  input  logic             bypass,
  input  logic [CH-1:0]    sampleIn,
  output logic             tick,
  output logic [REG_W-1:0] storedCnt,
  output logic [REG_W-1:0] storedNext,
  output logic [REG_W-1:0] preStored,
  output logic [AW-1:0]    wrPtr,
  output logic             memWrEn,
  output logic [AW-1:0]    memAddr,
  output logic [CH-1:0]    memWrData,
  output logic             streamValid,
  output logic [CH-1:0]    streamData
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLim;

  always_comb begin
    divLim = (divisor == '0) ? '0 : divisor - 1'b1;
    tick   = (divCnt == divLim);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (cmd.clear) begin
      divCnt <= '0;
    end else if (cmd.run) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
    end
  end

  always_comb begin
    storedNext = storedCnt + {{(REG_W-1){1'b0}}, cmd.advance};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storedCnt <= '0;
      preStored <= '0;
      wrPtr     <= '0;
    end else if (cmd.clear) begin
      storedCnt <= '0;
      preStored <= '0;
      wrPtr     <= '0;
    end else begin
      storedCnt <= storedNext;
      if (cmd.latchPre) preStored <= storedCnt;
      if (cmd.advance && !bypass) wrPtr <= wrPtr + 1'b1;
    end
  end

  always_comb begin
    memWrEn     = cmd.advance && !bypass;
    memAddr     = wrPtr;
    memWrData   = sampleIn;
    streamValid = cmd.advance && bypass;
    streamData  = sampleIn;
  end

  AST_WRITE_COUNTS: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> (storedCnt == $past(storedCnt) + 1)); // R8
  AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> (wrPtr == $past(wrPtr) + 1'b1)); // R5
  AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWrEn, streamValid})); // R11
  AST_STREAM_NO_PTR: assert property (@(posedge clk) disable iff (!rstN)
    streamValid |=> $stable(wrPtr)); // R11
endmodule

// File: rtl/pretrig_ctrl.sv
module pretrig_ctrl
  import pretrig_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              trigIn,
  input  logic              tick,
  input  logic [REG_W-1:0]  storedCnt,
  input  logic [REG_W-1:0]  storedNext,
  input  logic [REG_W-1:0]  preStored,
  input  logic [AW-1:0]     wrPtr,
  output dpCmd_t            cmd,
  output logic [DIV_W-1:0]  divisor,
  output logic              bypass
);
  capState_t state, nextState;
  logic [REG_W-1:0] totalCnt;
  logic [REG_W-1:0] preCnt;
  logic trigSeen;
  logic recording, runWr, startReq, stopReq, cfgWr, trigOk, reached;
  logic [1:0] phase;

  always_comb begin
    recording = (state == ST_PRE) || (state == ST_POST);
    runWr     = regWrEn && (regAddr == REG_RUN);
    startReq  = runWr && (regWrData == RUN_GO) && !recording;
    stopReq   = runWr && (regWrData == RUN_HALT);
    cfgWr     = regWrEn && !recording;
    trigOk    = (state == ST_PRE) && !bypass && trigIn && (storedCnt >= preCnt);
    reached   = (storedNext >= totalCnt);
  end

  always_comb begin
    cmd.clear    = startReq;
    cmd.run      = recording;
    cmd.advance  = recording && tick;
    cmd.latchPre = trigOk;
  end

  always_comb begin
    nextState = state;
    if (stopReq) begin
      nextState = ST_IDLE;
    end else if (startReq) begin
      nextState = ST_PRE;
    end else begin
      case (state)
        ST_PRE:  if (trigOk) nextState = reached ? ST_DONE : ST_POST;
        ST_POST: if (reached) nextState = ST_DONE;
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      trigSeen <= 1'b0;
    end else begin
      state <= nextState;
      if (startReq) trigSeen <= 1'b0;
      else if (trigOk) trigSeen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      totalCnt <= '0;
      preCnt   <= '0;
      divisor  <= '0;
      bypass   <= 1'b0;
    end else if (cfgWr) begin
      case (regAddr)
        REG_MODE:  bypass   <= regWrData[0];
        REG_TOTAL: totalCnt <= regWrData;
        REG_PRE:   preCnt   <= regWrData;
        REG_DIV:   divisor  <= regWrData[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_PRE, ST_POST: phase = PHASE_REC;
      ST_DONE:         phase = PHASE_DONE;
      default:         phase = PHASE_IDLE;
    endcase
  end

  always_comb begin
    case (regAddr)
      REG_RUN:   regRdData = {{(REG_W-4){1'b0}}, {2{trigSeen}}, phase};
      REG_MODE:  regRdData = {{(REG_W-1){1'b0}}, bypass};
      REG_TOTAL: regRdData = totalCnt;
      REG_PRE:   regRdData = preCnt;
      REG_DIV:   regRdData = {{(REG_W-DIV_W){1'b0}}, divisor};
      REG_CNT:   regRdData = storedCnt;
      REG_PREST: regRdData = preStored;
      default:   regRdData = {{(REG_W-AW){1'b0}}, wrPtr};
    endcase
  end

  AST_TRIG_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigSeen) |-> ($past(storedCnt) >= $past(preCnt))); // R6
  AST_POST_BELOW_TOTAL: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POST) |-> (storedCnt < totalCnt)); // R7
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_DONE) && !startReq) |=> (state inside {ST_DONE, ST_IDLE})); // R7
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (recording && regWrEn && (regAddr == REG_TOTAL)) |=> $stable(totalCnt)); // R10
  AST_BYPASS_NO_TRIG: assert property (@(posedge clk) disable iff (!rstN)
    bypass |-> (state != ST_POST)); // R11
endmodule

// File: rtl/pretrig_capture.sv
module pretrig_capture
  import pretrig_pkg::*;
#(
  parameter int CH = 16,
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [CH-1:0]     sampleIn,
  input  logic              trigIn,
  output logic              memWrEn,
  output logic [AW-1:0]     memAddr,
  output logic [CH-1:0]     memWrData,
  output logic              streamValid,
  output logic [CH-1:0]     streamData
);
  dpCmd_t           cmd;
  logic             tick;
  logic             bypass;
  logic [DIV_W-1:0] divisor;
  logic [REG_W-1:0] storedCnt, storedNext, preStored;
  logic [AW-1:0]    wrPtr;

  pretrig_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .trigIn(trigIn), .tick(tick),
    .storedCnt(storedCnt), .storedNext(storedNext), .preStored(preStored), .wrPtr(wrPtr),
    .cmd(cmd), .divisor(divisor), .bypass(bypass)
  );

  pretrig_dp #(.CH(CH), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .divisor(divisor), .bypass(bypass),
    .sampleIn(sampleIn), .tick(tick),
    .storedCnt(storedCnt), .storedNext(storedNext), .preStored(preStored), .wrPtr(wrPtr),
    .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData),
    .streamValid(streamValid), .streamData(streamData)
  );
endmodule

// File: tb/pretrig_capture_test.sv
module pretrig_capture_test;
  localparam int CH = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [2:0]    regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic [CH-1:0] sampleIn = '0;
  logic          trigIn = 1'b0;
  logic          memWrEn;
  logic [AW-1:0] memAddr;
  logic [CH-1:0] memWrData;
  logic          streamValid;
  logic [CH-1:0] streamData;

  pretrig_capture #(.CH(CH), .AW(AW)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sampleIn(sampleIn),
    .trigIn(trigIn), .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData),
    .streamValid(streamValid), .streamData(streamData)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  longint cycleCnt = 0;
  longint startCycle = 0;
  longint lastCycle = 0;
  int gap = 1;
  bit firstPending = 0;
  int wrCount = 0;
  int strCount = 0;
  int expQ[$];

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk); #2;
    sampleIn = sampleIn + 8'd7;
  end

  // monitor: pops expected addresses as writes appear
  initial forever begin
    @(negedge clk);
    if (rstN && memWrEn) begin
      wrCount++;
      if (expQ.size() == 0) begin
        check(0, "R7 unexpected memory write at addr", memAddr, -1);
      end else begin
        int e;
        e = expQ.pop_front();
        check(memAddr == e, "R5 write address", memAddr, e);
      end
      check(memWrData == sampleIn, "R5 write data", memWrData, sampleIn);
      if (firstPending)
        check(cycleCnt == startCycle + gap - 1, "R2 first sample cycle", cycleCnt - startCycle, gap - 1);
      else
        check(cycleCnt - lastCycle == gap, "R2 sample spacing", cycleCnt - lastCycle, gap);
      firstPending = 0;
      lastCycle = cycleCnt;
    end
    if (rstN && streamValid) begin
      strCount++;
      check(streamData == sampleIn, "R11 stream data", streamData, sampleIn);
    end
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    regAddr = a; #1;
    d = regRdData;
  endtask

  task automatic startRun(input int g);
    gap = g;
    firstPending = 1;
    regWrite(3'd0, 32'd3);
    startCycle = cycleCnt;
  endtask

  task automatic waitDone(input int maxCycles);
    logic [31:0] s;
    for (int i = 0; i < maxCycles; i++) begin
      @(posedge clk); #1;
      regRead(3'd0, s);
      if (s[1:0] == 2'd1) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int base, k;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    regRead(3'd0, rd); check(rd == 0, "R1 status after reset", rd, 0);
    regRead(3'd5, rd); check(rd == 0, "R1 stored count after reset", rd, 0);
    regRead(3'd6, rd); check(rd == 0, "R1 pre count after reset", rd, 0);
    regRead(3'd7, rd); check(rd == 0, "R1 position after reset", rd, 0);
    check(memWrEn == 0 && streamValid == 0, "R1 ports idle", memWrEn, 0);

    // R10 config readback, divisor 16 bits wide
    regWrite(3'd4, 32'h0003_ABCD);
    regRead(3'd4, rd); check(rd == 32'hABCD, "R10 divisor readback", rd, 32'hABCD);
    regWrite(3'd1, 32'd0);
    regWrite(3'd2, 32'd10);
    regWrite(3'd3, 32'd3);
    regWrite(3'd4, 32'd0);
    regRead(3'd2, rd); check(rd == 10, "R10 total readback", rd, 10);
    regRead(3'd3, rd); check(rd == 3, "R10 pre readback", rd, 3);

    // Test A: divisor 0, trigger held early
    trigIn = 1'b1;
    for (int i = 0; i < 10; i++) expQ.push_back(i % 16);
    startRun(1);
    regRead(3'd0, rd); check(rd == 32'h2, "R4 R6 recording, trigger deferred", rd, 2);
    waitDone(100);
    trigIn = 1'b0;
    regRead(3'd0, rd); check(rd == 32'hD, "R4 finished and triggered", rd, 13);
    regRead(3'd5, rd); check(rd == 10, "R8 stored count", rd, 10);
    regRead(3'd6, rd); check(rd == 3, "R6 pre count at trigger", rd, 3);
    regRead(3'd7, rd); check(rd == 10, "R8 final position", rd, 10);
    repeat (8) @(posedge clk); #1;
    check(expQ.size() == 0, "R7 all writes seen", expQ.size(), 0);

    // Test B: divisor 3, wrap, late trigger, config lock
    regWrite(3'd4, 32'd3);
    regWrite(3'd2, 32'd20);
    regWrite(3'd3, 32'd5);
    for (int i = 0; i < 20; i++) expQ.push_back(i % 16);
    base = wrCount;
    startRun(3);
    regWrite(3'd2, 32'd5);
    regRead(3'd2, rd); check(rd == 20, "R10 total locked while recording", rd, 20);
    regWrite(3'd0, 32'd2);
    regRead(3'd0, rd); check(rd == 32'h2, "R3 run code 2 ignored", rd, 2);
    while (wrCount - base < 9) begin @(posedge clk); #1; end
    k = wrCount - base;
    regRead(3'd0, rd); check(rd == 32'h2, "R4 recording before trigger", rd, 2);
    trigIn = 1'b1;
    @(posedge clk); #1;
    trigIn = 1'b0;
    waitDone(200);
    regRead(3'd0, rd); check(rd == 32'hD, "R4 finished after late trigger", rd, 13);
    regRead(3'd5, rd); check(rd == 20, "R7 stored equals total", rd, 20);
    regRead(3'd6, rd); check(rd == k, "R8 pre count at late trigger", rd, k);
    regRead(3'd7, rd); check(rd == 4, "R5 R8 wrapped final position", rd, 4);
    repeat (12) @(posedge clk); #1;
    check(expQ.size() == 0, "R7 writes complete", expQ.size(), 0);
    check(wrCount - base == 20, "R7 no writes past total", wrCount - base, 20);

    // Test C: stop mid-run
    regWrite(3'd4, 32'd2);
    regWrite(3'd2, 32'd100);
    regWrite(3'd3, 32'd50);
    for (int i = 0; i < 100; i++) expQ.push_back(i % 16);
    base = wrCount;
    startRun(2);
    while (wrCount - base < 7) begin @(posedge clk); #1; end
    regWrite(3'd0, 32'd0);
    expQ.delete();
    k = wrCount - base;
    repeat (10) @(posedge clk); #1;
    regRead(3'd0, rd); check(rd == 0, "R9 idle after stop", rd, 0);
    check(wrCount - base == k, "R9 no writes after stop", wrCount - base, k);
    regRead(3'd5, rd); check(rd == k, "R9 stored count kept", rd, k);
    regRead(3'd7, rd); check(rd == (k % 16), "R9 position kept", rd, k % 16);

    // Test D: bad run code while idle
    base = wrCount;
    regWrite(3'd0, 32'd5);
    repeat (8) @(posedge clk); #1;
    regRead(3'd0, rd); check(rd == 0, "R3 run code 5 ignored", rd, 0);
    check(wrCount == base, "R3 no writes from bad code", wrCount - base, 0);

    // Test E: streaming bypass
    regWrite(3'd1, 32'd1);
    regWrite(3'd2, 32'd3);
    regWrite(3'd3, 32'd0);
    trigIn = 1'b1;
    base = strCount;
    k = wrCount;
    startRun(2);
    repeat (30) @(posedge clk); #1;
    regRead(3'd0, rd); check(rd == 32'h2, "R11 trigger ignored, still recording", rd, 2);
    regWrite(3'd0, 32'd0);
    trigIn = 1'b0;
    @(posedge clk); #1;
    regRead(3'd5, rd); check(rd == strCount - base, "R11 stored count in streaming", rd, strCount - base);
    check(strCount - base >= 10, "R11 stream samples produced", strCount - base, 10);
    check(wrCount == k, "R11 no memory writes", wrCount - k, 0);
    regRead(3'd7, rd); check(rd == 0, "R11 position unchanged", rd, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule